// File: doc/BRIEF.md
# Instruction Fetch Sequencer

This block is the control state machine for the fetch half of a small bus-based accumulator processor. On every instruction it runs three bus transfers, one per clock. First the program counter is copied into the memory address register. Next the addressed memory word is written into the instruction register. Last the program counter is advanced. Each transfer is carried out by one-hot strobes that the datapath uses as drive and load enables on the shared bus.

The counter advance has a cycle of its own, after the instruction register has been written. As a result, the decision on where to go after fetch is always taken from an instruction register that already holds the new word. When the sequencer leaves the advance step it emits a one-cycle decode pulse together with the opcode. It then either waits in an execute-hold state until the execute logic signals completion, or, for opcodes flagged as fetch-only, starts the next fetch straight away.

Top module: `fetch_seq`

## Requirements
- R1: With `rst` high at a rising edge, the state is BOOT after that edge, and all strobes and `dec_pulse` are low. BOOT moves to ADDR on the first edge at which `rst` is low.
- R2: `state_o` is 8 bits wide with codes BOOT=0, ADDR=1, LOAD=2, ADV=3, EXEC=4.
- R3: In ADDR, `pc_to_bus` and `bus_to_mar` are high and every other strobe is low. ADDR lasts exactly one cycle and is followed by LOAD.
- R4: In LOAD, `ram_to_bus` and `bus_to_ir` are high, and `pc_count` and the ADDR strobes are low.
- R5: LOAD is always followed by ADV. In ADV, `pc_count` is the only strobe that is high, for exactly one cycle.
- R6: `pc_to_bus` and `ram_to_bus` are never high in the same cycle.
- R7: The opcode is `ir_word[7:4]`, sampled at the edge that ends ADV. `dec_pulse` is high for exactly the one cycle after ADV, and `dec_op` then shows that opcode.
- R8: After ADV, the next state is ADDR when bit `opcode` of `SKIP_MASK` is set (the default 16'h0001 flags only opcode 0), and EXEC otherwise.
- R9: In EXEC all strobes are low. The state stays EXEC while `exec_done` is low and moves to ADDR on the edge at which `exec_done` is high. `exec_done` has no effect in any other state.
- R10: Strobes and state do not depend on `ir_word` except at the edge that ends ADV. All strobes are register outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ir_word | input | IR_W (8) | Contents of the instruction register |
| exec_done | input | 1 | Execute phase finished |
| pc_to_bus | output | 1 | Program counter drives the bus |
| bus_to_mar | output | 1 | Address register loads from the bus |
| ram_to_bus | output | 1 | Memory drives the bus |
| bus_to_ir | output | 1 | Instruction register loads from the bus |
| pc_count | output | 1 | Program counter increments |
| dec_pulse | output | 1 | One-cycle decode entry |
| dec_op | output | OP_W (4) | Opcode carried with the decode entry |
| state_o | output | 8 | Current state code |

## Verification
Two events can land in the same cycle. The first case is the decode pulse arriving together with the completion of execute: the bench raises `exec_done` in the very first EXEC cycle and expects ADDR on the next edge, with the pulse not repeated. The second case is the decode pulse coinciding with the next fetch's address strobes: a fetch-only opcode sends ADV straight to ADDR, so the pulse and `dec_op` must appear while `pc_to_bus` and `bus_to_mar` are high. A datapath model in the bench moves real values on the strobes, so the opcode reaching the pulse shows that the strobes came in the correct order. Garbled `ir_word` values outside ADV, and `exec_done` held high during fetch, must leave every output unchanged.

// File: rtl/fetch_seq_pkg.sv
package fetch_seq_pkg;

   typedef enum logic [7:0] {
      FS_BOOT = 8'd0,
      FS_ADDR = 8'd1,
      FS_LOAD = 8'd2,
      FS_ADV  = 8'd3,
      FS_EXEC = 8'd4
   } fs_state_e;

   typedef struct packed {
      logic pc_to_bus;
      logic bus_to_mar;
      logic ram_to_bus;
      logic bus_to_ir;
      logic pc_count;
   } fs_strobe_t;

   localparam fs_strobe_t FS_QUIET = '{default: 1'b0};

   // strobe pattern belonging to each state
   function automatic fs_strobe_t fs_strobes(input fs_state_e st);
      fs_strobe_t s;
      s = FS_QUIET;
      case (st)
         FS_ADDR: begin
            s.pc_to_bus  = 1'b1;
            s.bus_to_mar = 1'b1;
         end
         FS_LOAD: begin
            s.ram_to_bus = 1'b1;
            s.bus_to_ir  = 1'b1;
         end
         FS_ADV:  s.pc_count = 1'b1;
         default: s = FS_QUIET;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/fetch_seq_next.sv
module fetch_seq_next
   import fetch_seq_pkg::*;
(
   input  fs_state_e cur_i,
   input  logic      skip_i,
   input  logic      done_i,
   output fs_state_e nxt_o
);

   always_comb begin
      nxt_o = cur_i;
      case (cur_i)
         FS_BOOT: nxt_o = FS_ADDR;
         FS_ADDR: nxt_o = FS_LOAD;
         FS_LOAD: nxt_o = FS_ADV;
         FS_ADV:  nxt_o = skip_i ? FS_ADDR : FS_EXEC;
         FS_EXEC: nxt_o = done_i ? FS_ADDR : FS_EXEC;
         default: nxt_o = FS_BOOT;
      endcase
   end

endmodule

// File: rtl/fetch_seq_opsel.sv
module fetch_seq_opsel
   import fetch_seq_pkg::*;
#(
   parameter int                   IR_W      = 8,
   parameter int                   OP_W      = 4,
   parameter logic [(1<<OP_W)-1:0] SKIP_MASK = 16'h0001
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [IR_W-1:0] ir_i,
   input  fs_state_e       cur_i,
   output logic            skip_o,
   output logic            pulse_o,
   output logic [OP_W-1:0] op_o
);

   localparam int LO_W = IR_W - OP_W;

   logic [OP_W-1:0] opcode;
   assign opcode = ir_i[IR_W-1 -: OP_W];

   generate
      if (LO_W > 0) begin : g_low
         logic unused_low;
         assign unused_low = ^ir_i[LO_W-1:0];
      end
   endgenerate

   generate
      if (SKIP_MASK == '0) begin : g_noskip
         assign skip_o = 1'b0;
      end else begin : g_skip
         assign skip_o = SKIP_MASK[opcode];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         pulse_o <= 1'b0;
         op_o    <= '0;
      end else begin
         pulse_o <= (cur_i == FS_ADV);
         if (cur_i == FS_ADV)
            op_o <= opcode;
      end
   end

endmodule

// File: rtl/fetch_seq_outreg.sv
module fetch_seq_outreg
   import fetch_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  fs_state_e  nxt_i,
   output fs_state_e  cur_o,
   output fs_strobe_t strb_o
);

   always_ff @(posedge clk) begin
      if (rst) begin
         cur_o  <= FS_BOOT;
         strb_o <= FS_QUIET;
      end else begin
         cur_o  <= nxt_i;
         strb_o <= fs_strobes(nxt_i);
      end
   end

endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
   import fetch_seq_pkg::*;
#(
   parameter int                   IR_W      = 8,
   parameter int                   OP_W      = 4,
   parameter logic [(1<<OP_W)-1:0] SKIP_MASK = 16'h0001
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [IR_W-1:0] ir_word,
   input  logic            exec_done,
   output logic            pc_to_bus,
   output logic            bus_to_mar,
   output logic            ram_to_bus,
   output logic            bus_to_ir,
   output logic            pc_count,
   output logic            dec_pulse,
   output logic [OP_W-1:0] dec_op,
   output logic [7:0]      state_o
);

   generate
      if (OP_W < 1 || OP_W > IR_W) begin : g_bad_op
         $error("fetch_seq: OP_W must lie in 1..IR_W");
      end
      if (OP_W > 8) begin : g_bad_mask
         $error("fetch_seq: OP_W above 8 makes SKIP_MASK too wide");
      end
   endgenerate

   fs_state_e  cur_st;
   fs_state_e  nxt_st;
   fs_strobe_t strb;
   logic       skip;

   fetch_seq_opsel #(
      .IR_W      (IR_W),
      .OP_W      (OP_W),
      .SKIP_MASK (SKIP_MASK)
   ) u_opsel (
      .clk     (clk),
      .rst     (rst),
      .ir_i    (ir_word),
      .cur_i   (cur_st),
      .skip_o  (skip),
      .pulse_o (dec_pulse),
      .op_o    (dec_op)
   );

   fetch_seq_next u_next (
      .cur_i  (cur_st),
      .skip_i (skip),
      .done_i (exec_done),
      .nxt_o  (nxt_st)
   );

   fetch_seq_outreg u_outreg (
      .clk    (clk),
      .rst    (rst),
      .nxt_i  (nxt_st),
      .cur_o  (cur_st),
      .strb_o (strb)
   );

   assign pc_to_bus  = strb.pc_to_bus;
   assign bus_to_mar = strb.bus_to_mar;
   assign ram_to_bus = strb.ram_to_bus;
   assign bus_to_ir  = strb.bus_to_ir;
   assign pc_count   = strb.pc_count;
   assign state_o    = cur_st;

endmodule

// File: rtl/fetch_seq_chk.sv
module fetch_seq_chk #(
   parameter int OP_W = 4
) (
   input logic            clk,
   input logic            rst,
   input logic [OP_W-1:0] op_i,
   input logic            exec_done,
   input logic            pc_to_bus,
   input logic            bus_to_mar,
   input logic            ram_to_bus,
   input logic            bus_to_ir,
   input logic            pc_count,
   input logic            dec_pulse,
   input logic [OP_W-1:0] dec_op,
   input logic [7:0]      state_o
);

   logic [4:0] strb;
   assign strb = {pc_to_bus, bus_to_mar, ram_to_bus, bus_to_ir, pc_count};

   p_reset_r1: assert property (@(posedge clk)
      rst |=> (state_o == 8'd0 && strb == 5'b0 && !dec_pulse));

   p_boot_exit_r1: assert property (@(posedge clk) disable iff (rst)
      state_o == 8'd0 |=> state_o == 8'd1);

   p_state_legal_r2: assert property (@(posedge clk) disable iff (rst)
      state_o <= 8'd4);

   p_addr_strobes_r3: assert property (@(posedge clk) disable iff (rst)
      state_o == 8'd1 |-> strb == 5'b11000);

   p_addr_once_r3: assert property (@(posedge clk) disable iff (rst)
      state_o == 8'd1 |=> state_o == 8'd2);

   p_load_strobes_r4: assert property (@(posedge clk) disable iff (rst)
      state_o == 8'd2 |-> strb == 5'b00110);

   p_load_to_adv_r5: assert property (@(posedge clk) disable iff (rst)
      state_o == 8'd2 |=> state_o == 8'd3);

   p_adv_strobes_r5: assert property (@(posedge clk) disable iff (rst)
      state_o == 8'd3 |-> strb == 5'b00001);

   p_one_driver_r6: assert property (@(posedge clk) disable iff (rst)
      $onehot0({pc_to_bus, ram_to_bus}));

   p_dec_entry_r7: assert property (@(posedge clk) disable iff (rst)
      state_o == 8'd3 |=> (dec_pulse && dec_op == $past(op_i)));

   p_dec_single_r7: assert property (@(posedge clk) disable iff (rst)
      state_o != 8'd3 |=> !dec_pulse);

   p_after_adv_r8: assert property (@(posedge clk) disable iff (rst)
      state_o == 8'd3 |=> (state_o == 8'd4 || state_o == 8'd1));

   p_exec_quiet_r9: assert property (@(posedge clk) disable iff (rst)
      state_o == 8'd4 |-> strb == 5'b0);

   p_exec_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (state_o == 8'd4 && !exec_done) |=> state_o == 8'd4);

   p_exec_leave_r9: assert property (@(posedge clk) disable iff (rst)
      (state_o == 8'd4 && exec_done) |=> state_o == 8'd1);

endmodule

bind fetch_seq fetch_seq_chk #(.OP_W(OP_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .op_i       (ir_word[IR_W-1 -: OP_W]),
   .exec_done  (exec_done),
   .pc_to_bus  (pc_to_bus),
   .bus_to_mar (bus_to_mar),
   .ram_to_bus (ram_to_bus),
   .bus_to_ir  (bus_to_ir),
   .pc_count   (pc_count),
   .dec_pulse  (dec_pulse),
   .dec_op     (dec_op),
   .state_o    (state_o)
);

// File: tb/fetch_seq_tb.sv
`timescale 1ns/1ps
module fetch_seq_tb;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       exec_done = 1'b0;
   logic [7:0] garble = 8'h00;
   logic       pc_to_bus, bus_to_mar, ram_to_bus, bus_to_ir, pc_count;
   logic       dec_pulse;
   logic [3:0] dec_op;
   logic [7:0] state_o;

   // datapath model
   logic [3:0] m_pc  = 4'd0;
   logic [3:0] m_mar = 4'd0;
   logic [7:0] m_ir  = 8'd0;
   logic [7:0] ir_word;
   assign ir_word = m_ir ^ garble;

   int n_cmp  = 0;
   int n_bad  = 0;
   int cycles = 0;

   always #4 clk = ~clk;   // 125 MHz

   fetch_seq u_dut (
      .clk        (clk),
      .rst        (rst),
      .ir_word    (ir_word),
      .exec_done  (exec_done),
      .pc_to_bus  (pc_to_bus),
      .bus_to_mar (bus_to_mar),
      .ram_to_bus (ram_to_bus),
      .bus_to_ir  (bus_to_ir),
      .pc_count   (pc_count),
      .dec_pulse  (dec_pulse),
      .dec_op     (dec_op),
      .state_o    (state_o)
   );

   // memory word at address a: opcode a, operand ~a
   function automatic logic [7:0] mem_at(input logic [3:0] a);
      return {a, ~a};
   endfunction

   always @(posedge clk) begin
      if (pc_to_bus && bus_to_mar) m_mar <= m_pc;
      if (ram_to_bus && bus_to_ir) m_ir  <= mem_at(m_mar);
      if (pc_count)                m_pc  <= m_pc + 4'd1;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [4:0] strobes();
      return {pc_to_bus, bus_to_mar, ram_to_bus, bus_to_ir, pc_count};
   endfunction

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      check("R6 single bus driver", 32'(pc_to_bus & ram_to_bus), 0);
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         finish_run();
      end
   end

   initial begin
      logic       prev_skip;
      logic [3:0] prev_op;
      logic [3:0] op;
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 reset state", 32'(state_o), 0);
      check("R1 reset strobes", 32'(strobes()), 0);
      check("R1 reset pulse", 32'(dec_pulse), 0);
      rst = 1'b0;
      step();
      prev_skip = 1'b0;
      prev_op   = 4'd0;
      for (int i = 0; i < 48; i++) begin
         op = 4'(i);
         // ADDR cycle, with garbled IR and exec_done noise
         garble    = 8'(8'h5A + i * 8'd29) | 8'h01;
         exec_done = i[0];
         check("R2/R3 addr state", 32'(state_o), 1);
         check("R3/R10 addr strobes", 32'(strobes()), 32'b11000);
         check("R7/R8 pulse on addr", 32'(dec_pulse), 32'(prev_skip));
         if (prev_skip) check("R7 skip op", 32'(dec_op), 32'(prev_op));
         step();
         check("R3 mar loaded", 32'(m_mar), 32'(op));
         check("R2/R4 load state", 32'(state_o), 2);
         check("R4 load strobes", 32'(strobes()), 32'b00110);
         check("R7 no pulse in load", 32'(dec_pulse), 0);
         garble = 8'h00;
         step();
         check("R2/R5 adv state", 32'(state_o), 3);
         check("R5 adv strobes", 32'(strobes()), 32'b00001);
         check("R4 ir loaded", 32'(m_ir), 32'(mem_at(op)));
         step();
         check("R7 pulse after adv", 32'(dec_pulse), 1);
         check("R7 dec_op", 32'(dec_op), 32'(op));
         prev_op = op;
         if (op == 4'd0) begin
            // R8: fetch-only opcode, pulse together with next ADDR
            prev_skip = 1'b1;
            check("R8 skip to addr", 32'(state_o), 1);
         end else begin
            prev_skip = 1'b0;
            check("R2/R8 exec state", 32'(state_o), 4);
            check("R9 exec strobes", 32'(strobes()), 0);
            garble = 8'hF0;
            exec_done = (i % 3 == 0);
            for (int d = 0; d < i % 3; d++) begin
               step();
               check("R9 exec hold", 32'(state_o), 4);
               check("R9/R10 exec quiet", 32'(strobes()), 0);
               check("R7 single pulse", 32'(dec_pulse), 0);
               if (d == (i % 3) - 1) exec_done = 1'b1;
            end
            step();
            exec_done = 1'b0;
         end
      end
      // R1: reset taken in the middle of a fetch
      garble = 8'h00;
      exec_done = 1'b0;
      step();
      check("R3 pre-reset load", 32'(state_o), 2);
      rst = 1'b1;
      step();
      check("R1 mid-fetch reset state", 32'(state_o), 0);
      check("R1 mid-fetch reset strobes", 32'(strobes()), 0);
      rst = 1'b0;
      step();
      check("R1 boot exit", 32'(state_o), 1);
      finish_run();
   end

endmodule